// File: doc/BRIEF.md
# Balanced Idle Protection Controller

The controller produces two alternating pulse-width-modulated outputs from one free-running period counter. Output A is driven in even periods and output B in odd periods, each active at the start of its period for a programmed number of counter ticks. A protection trigger stops the waveforms in a balanced way. The pulse in progress is cut at once. The next period then gives the other output a pulse of the same truncated length, so both outputs carry the same energy. After that, both outputs are frozen at a configurable idle level.

When an automatic-resume option is valid, the controller skips the frozen state after the balancing pulse and returns to normal running with the programmed width. A burst request pair (enter and exit) can silence the outputs. A protection event takes priority over a burst exit. Set and reset event strobes follow the programmed schedule in every state, including while the outputs are frozen, so downstream capture or request logic keeps receiving them.

Top module: `balidle_ctrl`

## Requirements
- R1: During and right after reset the counter is at 0 in the A phase, no protection or burst is active, and `idle_flag` is low. `out_a` is therefore high in the first cycle (for width ≥ 1) and `set_evt` is high.
- R2: In run mode the counter counts 0 up to `period`-1 and then wraps (it also wraps when at or beyond `period`-1). The phase toggles at each wrap. The output of the current phase (A = even, B = odd) is 1 exactly while counter < `width`, the other output is 0, and the active level is 1.
- R3: `set_evt` is 1 whenever the counter is 0, and `rst_evt` is 1 whenever the counter equals `width`, in every state including idle.
- R4: A `prot_trig` sampled high in run mode forces both outputs to 0 from the next cycle. If an output was active, the captured width is counter+1 (the trigger cycle counts as active). Otherwise the captured width is 0.
- R5: In the period after the trigger period, the output of that period's phase (the alternate output) is 1 for its first captured-width ticks and 0 for the rest. The other output stays 0.
- R6: Without valid auto-resume, both outputs hold `idle_lvl` and `idle_flag` is 1 after the balancing period. This lasts until a `restart` pulse, which returns the block to run mode in the next cycle.
- R7: Auto-resume is valid only when `ar_en`=1, `prot_mode` is 3'b011 or 3'b111, `idle_lvl`=0, and `period` > (192 >> `presc`). When it is valid, run mode with the programmed width resumes at the end of the balancing period and `idle_flag` stays 0.
- R8: `burst_enter` forces both outputs to 0 in run mode from the next cycle. A `burst_exit` in run mode, with no trigger in the same cycle, restores the waveforms. Enter wins if both requests arrive together.
- R9: A `burst_exit` that arrives while the protection is in progress or idle (or in the same cycle as the trigger) is discarded, and burst stays active.
- R10: Burst mode that is still active when the protection ends (through auto-resume or restart) continues, and the outputs stay 0 until a later `burst_exit`.
- R11: `prot_trig` has no effect unless the block is in run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period | input | W | Period length in counter ticks (≥ 2) |
| width | input | W | Programmed pulse width (1 ≤ width < period) |
| presc | input | 3 | Prescale code used to qualify auto-resume |
| prot_mode | input | 3 | Protection mode code |
| ar_en | input | 1 | Auto-resume request |
| idle_lvl | input | 1 | Output level while idle |
| prot_trig | input | 1 | Protection trigger |
| burst_enter | input | 1 | Burst entry request |
| burst_exit | input | 1 | Burst exit request |
| restart | input | 1 | Leaves idle and returns to run |
| out_a | output | 1 | Waveform A |
| out_b | output | 1 | Waveform B |
| set_evt | output | 1 | Scheduled set event strobe |
| rst_evt | output | 1 | Scheduled reset event strobe |
| idle_flag | output | 1 | High while frozen in idle |

## Verification
The bench tries triggers in four places: early inside an A pulse, inside a B pulse, outside any pulse, and while a burst is active. Comparing these shows whether the captured width comes from the counter or from the schedule, and whether the balancing pulse lands on the correct alternate output. Auto-resume is run once under valid conditions and then with each of the qualifiers made invalid in turn: prescale threshold, mode code and idle level. This tells correct gating apart from a one-term check. Burst exits are issued both before and during a protection, which shows whether the priority rule and the persistence of burst after resume are handled.

// File: rtl/balidle_pkg.sv
// Package: shared state encoding for the balanced idle controller.
// Assumes: consumers import it before use.
package balidle_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_COPY = 2'd2,
        ST_IDLE = 2'd3
    } bip_state_t;
endpackage

// File: rtl/balidle_counter.sv
// Period counter: counts 0..period-1, toggles the output phase on each wrap.
// Assumes: period >= 2; a counter at or above period-1 wraps on the next edge.
module balidle_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         phase,
    output logic         period_end
);
    // Wrap condition, tolerant of a period shrinking below the count.
    always_comb period_end = (cnt >= period - W'(1));

    // Advance the counter and the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (period_end) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (cnt == '0));
endmodule

// File: rtl/balidle_fsm.sv
// Protection sequencer: run, wait for alternate set point, copy, idle.
// Also holds the burst flag and applies the burst/protection priority.
// Assumes: trigger and requests are synchronous single-cycle or level inputs.
module balidle_fsm
    import balidle_pkg::*;
#(
    parameter int W    = 10,
    parameter int THR0 = 192
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period,
    input  logic [W-1:0] cnt,
    input  logic         period_end,
    input  logic         pulse_live,
    input  logic [2:0]   presc,
    input  logic [2:0]   prot_mode,
    input  logic         ar_en,
    input  logic         idle_lvl,
    input  logic         prot_trig,
    input  logic         burst_enter,
    input  logic         burst_exit,
    input  logic         restart,
    output bip_state_t   state,
    output logic [W-1:0] cap_w,
    output logic         burst
);
    localparam logic [W-1:0] THR_BASE = W'(THR0);

    logic [W-1:0] thr;
    logic         ar_ok;

    // Auto-resume qualification: mode code, idle level and period threshold.
    always_comb begin
        thr   = THR_BASE >> presc;
        ar_ok = ar_en && (prot_mode[1:0] == 2'b11) && !idle_lvl && (period > thr);
    end

    // Protection sequence and captured width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cap_w <= '0;
        end else begin
            unique case (state)
                ST_RUN: if (prot_trig) begin
                    state <= ST_WAIT;
                    cap_w <= pulse_live ? cnt + W'(1) : '0;
                end
                ST_WAIT: if (period_end) state <= ST_COPY;
                ST_COPY: if (period_end) state <= ar_ok ? ST_RUN : ST_IDLE;
                ST_IDLE: if (restart) state <= ST_RUN;
                default: state <= ST_RUN;
            endcase
        end
    end

    // Burst flag; exits are only honoured in run mode without a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)
            burst <= 1'b0;
        else if (burst_enter)
            burst <= 1'b1;
        else if (burst_exit && state == ST_RUN && !prot_trig)
            burst <= 1'b0;
    end

    a_r9_burst_exit_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && burst && burst_exit) |=> burst);
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !restart) |=> (state == ST_IDLE));
    a_r11_trig_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !period_end) |=> (state == ST_WAIT && $stable(cap_w)));
endmodule

// File: rtl/balidle_outstage.sv
// Output stage: maps state, phase and counter onto the two waveforms and
// the scheduled set/reset strobes.
// Assumes: active level is 1; the idle level applies only in the idle state.
module balidle_outstage
    import balidle_pkg::*;
#(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  bip_state_t   state,
    input  logic         phase,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] width,
    input  logic [W-1:0] cap_w,
    input  logic         burst,
    input  logic         idle_lvl,
    output logic         pulse_live,
    output logic         out_a,
    output logic         out_b,
    output logic         set_evt,
    output logic         rst_evt
);
    logic drive;

    // Select the level of the active-phase output for the current state.
    always_comb begin
        pulse_live = (state == ST_RUN) && !burst && (cnt < width);
        unique case (state)
            ST_RUN:  drive = pulse_live;
            ST_COPY: drive = (cnt < cap_w);
            default: drive = 1'b0;
        endcase
        if (state == ST_IDLE) begin
            out_a = idle_lvl;
            out_b = idle_lvl;
        end else begin
            out_a = drive && !phase;
            out_b = drive && phase;
        end
    end

    // Scheduled event strobes, independent of the protection state.
    always_comb begin
        set_evt = (cnt == '0);
        rst_evt = (cnt == width);
    end

    a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> $onehot0({out_a, out_b}));
endmodule

// File: rtl/balidle_ctrl.sv
// Top: balanced idle protection controller for two alternating outputs.
// Assumes: 1 <= width < period; all inputs synchronous to clk.
module balidle_ctrl
    import balidle_pkg::*;
#(
    parameter int W    = 10,
    parameter int THR0 = 192
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period,
    input  logic [W-1:0] width,
    input  logic [2:0]   presc,
    input  logic [2:0]   prot_mode,
    input  logic         ar_en,
    input  logic         idle_lvl,
    input  logic         prot_trig,
    input  logic         burst_enter,
    input  logic         burst_exit,
    input  logic         restart,
    output logic         out_a,
    output logic         out_b,
    output logic         set_evt,
    output logic         rst_evt,
    output logic         idle_flag
);
    logic [W-1:0] cnt;
    logic [W-1:0] cap_w;
    logic         phase;
    logic         period_end;
    logic         pulse_live;
    logic         burst;
    bip_state_t   state;

    balidle_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .period(period),
        .cnt(cnt), .phase(phase), .period_end(period_end)
    );

    balidle_fsm #(.W(W), .THR0(THR0)) u_fsm (
        .clk(clk), .rst_n(rst_n), .period(period), .cnt(cnt),
        .period_end(period_end), .pulse_live(pulse_live), .presc(presc),
        .prot_mode(prot_mode), .ar_en(ar_en), .idle_lvl(idle_lvl),
        .prot_trig(prot_trig), .burst_enter(burst_enter),
        .burst_exit(burst_exit), .restart(restart),
        .state(state), .cap_w(cap_w), .burst(burst)
    );

    balidle_outstage #(.W(W)) u_out (
        .clk(clk), .rst_n(rst_n), .state(state), .phase(phase), .cnt(cnt),
        .width(width), .cap_w(cap_w), .burst(burst), .idle_lvl(idle_lvl),
        .pulse_live(pulse_live), .out_a(out_a), .out_b(out_b),
        .set_evt(set_evt), .rst_evt(rst_evt)
    );

    // Idle status straight from the sequencer state.
    always_comb idle_flag = (state == ST_IDLE);

    a_r4_cut_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && prot_trig && (out_a || out_b)) |=> (!out_a && !out_b));
endmodule

// File: tb/sim_balidle_ctrl.sv
module sim_balidle_ctrl;
    localparam int W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] period = 20, width = 7;
    logic [2:0] presc = 0, prot_mode = 0;
    logic ar_en = 0, idle_lvl = 0, prot_trig = 0;
    logic burst_enter = 0, burst_exit = 0, restart = 0;
    logic out_a, out_b, set_evt, rst_evt, idle_flag;

    int n_chk = 0, n_fail = 0, cyc = 0;
    string tag = "R1";

    // reference model state: st 0 run, 1 wait, 2 copy, 3 idle
    int m_cnt, m_ph, m_st, m_cap, m_b;

    always #10 clk = ~clk;

    balidle_ctrl #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .period(period), .width(width),
        .presc(presc), .prot_mode(prot_mode), .ar_en(ar_en),
        .idle_lvl(idle_lvl), .prot_trig(prot_trig),
        .burst_enter(burst_enter), .burst_exit(burst_exit),
        .restart(restart), .out_a(out_a), .out_b(out_b),
        .set_evt(set_evt), .rst_evt(rst_evt), .idle_flag(idle_flag)
    );

    function automatic bit ar_valid();
        return ar_en && (prot_mode == 3'b011 || prot_mode == 3'b111) &&
               !idle_lvl && (int'(period) > (192 >> presc));
    endfunction

    always @(posedge clk) begin
        int pe, nc, np, ns, ncap, nb, live;
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_ph = 0; m_st = 0; m_cap = 0; m_b = 0;
        end else begin
            pe = (m_cnt >= int'(period) - 1);
            nc = pe ? 0 : m_cnt + 1;
            np = pe ? 1 - m_ph : m_ph;
            live = (m_st == 0) && !m_b && (m_cnt < int'(width));
            ns = m_st; ncap = m_cap; nb = m_b;
            if (m_st == 0 && prot_trig) begin ns = 1; ncap = live ? m_cnt + 1 : 0; end
            else if (m_st == 1 && pe) ns = 2;
            else if (m_st == 2 && pe) ns = ar_valid() ? 0 : 3;
            else if (m_st == 3 && restart) ns = 0;
            if (burst_enter) nb = 1;
            else if (burst_exit && m_st == 0 && !prot_trig) nb = 0;
            m_cnt = nc; m_ph = np; m_st = ns; m_cap = ncap; m_b = nb;
        end
    end

    task automatic chk(string t, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", t, what, act, exp, cyc);
        end
    endtask

    // per-cycle comparison with the model, away from the active edge
    always @(negedge clk) begin
        int ea, eb, drv;
        if (rst_n) begin
            drv = 0;
            if (m_st == 0) drv = !m_b && (m_cnt < int'(width));
            else if (m_st == 2) drv = (m_cnt < m_cap);
            if (m_st == 3) begin ea = idle_lvl; eb = idle_lvl; end
            else begin ea = drv && (m_ph == 0); eb = drv && (m_ph == 1); end
            chk(tag, "out_a", out_a, ea);
            chk(tag, "out_b", out_b, eb);
            chk("R3", "set_evt", set_evt, m_cnt == 0);
            chk("R3", "rst_evt", rst_evt, m_cnt == int'(width));
            chk(tag, "idle_flag", idle_flag, m_st == 3);
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_for(int c, int ph);
        int guard = 0;
        while (!(m_cnt == c && m_ph == ph) && guard < 2000) begin
            @(negedge clk); guard++;
        end
    endtask

    task automatic pulse_trig();
        prot_trig = 1; @(negedge clk); prot_trig = 0;
    endtask

    task automatic pulse_restart();
        restart = 1; @(negedge clk); restart = 0;
    endtask

    initial begin
        cycles(3);
        rst_n = 1;
        tag = "R1";
        chk("R1", "out_a after reset", out_a, 1);
        chk("R1", "set_evt after reset", set_evt, 1);
        chk("R1", "idle_flag after reset", idle_flag, 0);
        tag = "R2"; cycles(60);

        // trigger inside an A pulse: cut, copy onto B, then idle
        tag = "R4"; wait_for(3, 0); pulse_trig();
        chk("R4", "out_a cut", out_a, 0);
        tag = "R5"; cycles(40);
        tag = "R6"; chk("R6", "idle_flag", idle_flag, 1);
        tag = "R11"; pulse_trig(); cycles(5);
        tag = "R6"; pulse_restart();
        chk("R6", "idle_flag after restart", idle_flag, 0);
        tag = "R2"; cycles(45);

        // trigger inside a B pulse, and outside any pulse
        tag = "R5"; wait_for(5, 1); pulse_trig(); cycles(45); pulse_restart();
        tag = "R4"; wait_for(12, 0); pulse_trig(); cycles(45); pulse_restart();

        // burst enter/exit in run
        tag = "R8"; burst_enter = 1; @(negedge clk); burst_enter = 0;
        cycles(25);
        burst_exit = 1; @(negedge clk); burst_exit = 0;
        cycles(25);

        // burst exit during protection is discarded
        tag = "R9"; burst_enter = 1; @(negedge clk); burst_enter = 0;
        wait_for(2, 0); pulse_trig();
        burst_exit = 1; @(negedge clk); burst_exit = 0;
        cycles(45); pulse_restart();
        tag = "R10"; cycles(25);
        burst_exit = 1; @(negedge clk); burst_exit = 0;
        tag = "R2"; cycles(30);

        // valid auto-resume
        period = 60; presc = 2; prot_mode = 3'b011; ar_en = 1; idle_lvl = 0;
        tag = "R7"; cycles(130);
        wait_for(4, 0); pulse_trig(); cycles(150);
        chk("R7", "idle_flag with auto-resume", idle_flag, 0);

        // prescale makes threshold too high
        presc = 1; wait_for(6, 1); pulse_trig(); cycles(150);
        chk("R7", "idle_flag presc too high", idle_flag, 1);
        pulse_restart();
        // mode code not eligible
        presc = 2; prot_mode = 3'b101; wait_for(3, 0); pulse_trig(); cycles(150);
        chk("R7", "idle_flag mode 101", idle_flag, 1);
        pulse_restart();
        // idle level active disables resume, outputs at level 1
        prot_mode = 3'b111; idle_lvl = 1; wait_for(3, 1); pulse_trig(); cycles(150);
        chk("R7", "idle_flag idle_lvl=1", idle_flag, 1);
        chk("R6", "out_a idle level", out_a, 1);
        pulse_restart(); idle_lvl = 0;
        tag = "R7"; wait_for(8, 0); pulse_trig(); cycles(150);

        // burst persists through auto-resume
        tag = "R10"; burst_enter = 1; @(negedge clk); burst_enter = 0;
        wait_for(1, 1); pulse_trig();
        burst_exit = 1; @(negedge clk); burst_exit = 0;
        cycles(200);
        chk("R10", "out_a burst after resume", out_a, 0);
        burst_exit = 1; @(negedge clk); burst_exit = 0;
        tag = "R2"; cycles(130);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule